// File: doc/BRIEF.md
# Streaming Byte Realigner Between Two Word Buses

This block sits between a 32-bit memory-side stream and a 32-bit I/O-side stream. It is used when a transfer's first byte lies at one byte offset within a source word and must land at a different byte offset within a destination word. A transfer begins with a configuration handshake that supplies the source offset, the destination offset and the byte count. Source words then flow in over a valid/ready stream, and realigned destination words flow out with one enable bit per byte lane.

A holding register keeps the previous source word. A lane rotation by the offset difference, followed by a lane-wise merge of that held word with the word now arriving, produces each output word. This sustains one word per cycle whatever the two offsets are. The block may emit one extra word after the last source word, drawn from the holding register alone, when the tail of the data spills into a further destination word. It may also need one extra source word before the first output, when the source offset is larger than the destination offset.

Byte lane k of a word occupies bits [8k+7:8k], and lane 0 holds the lowest byte address. The source stream's valid bytes start at lane `cfg_src_off` of source word 0. Destination word 0 is the word containing destination offset `cfg_dst_off`.

Top module: `byte_realigner`

## Requirements
- R1: After synchronous reset, `cfg_ready` is 1 while `out_valid` and `in_ready` are both 0.
- R2: Stream byte n, located at source lane position `cfg_src_off`+n counted from lane 0 of source word 0, appears on the output at destination position `cfg_dst_off`+n. Position p sits in output word p/4 at lane p mod 4.
- R3: Output word 0 has `out_be` cleared for every lane below `cfg_dst_off`.
- R4: Every output word has at least one enable set. The final word enables lanes 0 up to lane (`cfg_dst_off`+count-1) mod 4, and words strictly between the first and the last enable all four lanes.
- R5: Exactly ceil((`cfg_dst_off`+count)/4) output words are produced, and `out_last` is 1 on the final one only. When the final source word does not complete the final destination word, one flush word is emitted with `in_ready` held low.
- R6: With input valid and output ready held high, a transfer completes in S+F cycles, where S = ceil((`cfg_src_off`+count)/4) and F is 1 when a flush word is needed and 0 otherwise.
- R7: While `out_ready` is low, no source word is accepted, except the single priming source word 0 when `cfg_src_off` > `cfg_dst_off`. No byte is lost or repeated.
- R8: `start` is taken only while `cfg_ready` is 1, and `cfg_count` must then be nonzero. `cfg_ready` stays 0 until the final output word is accepted, and it returns to 1 in the next cycle. A `start` pulse while busy has no effect on the output.
- R9: Exactly S source words are accepted per transfer, and `in_ready` is 0 once they have all been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer with the cfg_* values |
| cfg_src_off | input | 2 | Byte lane of the first source byte |
| cfg_dst_off | input | 2 | Byte lane of the first destination byte |
| cfg_count | input | 12 | Bytes to move, 1 or more |
| cfg_ready | output | 1 | Idle and able to accept start |
| in_valid | input | 1 | Source word present |
| in_ready | output | 1 | Source word accepted this cycle |
| in_data | input | 32 | Source word |
| out_valid | output | 1 | Destination word present |
| out_ready | input | 1 | Sink accepts destination word |
| out_data | output | 32 | Realigned destination word |
| out_be | output | 4 | Per-lane byte enables |
| out_last | output | 1 | Final destination word of transfer |

## Verification
On every cycle, the assertions check the following. A non-priming source word is consumed only together with an output word. A started transfer drops `cfg_ready`. The last output returns the block to idle. No emitted word has an empty enable mask. Byte placement across all sixteen offset pairs, the exact enable patterns of the first and last words, the presence of the flush word and the cycle count at full rate can only be shown by the bench's sweep. That sweep compares every output word against positions computed from the offsets and the count, under both a free-flowing sink and an irregular stalling sink.

// File: rtl/aln_pkg.sv
package aln_pkg;

    localparam int unsigned LANES = 4;
    localparam int unsigned CNT_W = 12;
    localparam int unsigned OFF_W = $clog2(LANES);
    localparam int unsigned DW    = 8 * LANES;
    localparam int unsigned WCNT_W = CNT_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } aln_state_e;

    typedef struct packed {
        logic [OFF_W-1:0] src_off;
        logic [OFF_W-1:0] dst_off;
        logic [CNT_W-1:0] count;
    } aln_cfg_t;

    // Number of whole words touched by n bytes starting at lane off.
    function automatic logic [WCNT_W-1:0] words_spanned(
        input logic [OFF_W-1:0] off,
        input logic [CNT_W-1:0] n
    );
        logic [CNT_W+1:0] tot;
        tot = {2'b00, n} + (CNT_W+2)'(off) + (CNT_W+2)'(LANES - 1);
        return WCNT_W'(tot >> OFF_W);
    endfunction

    // Upper word = current, lower word = held; take the window that
    // moves lanes up by sh.
    function automatic logic [DW-1:0] lane_merge(
        input logic [DW-1:0]    cur,
        input logic [DW-1:0]    held,
        input logic [OFF_W-1:0] sh
    );
        logic [2*DW-1:0] pair;
        logic [DW-1:0]   res;
        pair = {cur, held};
        res  = cur;
        for (int s = 0; s < LANES; s++) begin
            if (sh == OFF_W'(s)) res = pair[8*(LANES-s) +: DW];
        end
        return res;
    endfunction

endpackage

// File: rtl/aln_ctrl.sv
module aln_ctrl
    import aln_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  aln_cfg_t             cfg,
    output logic                 cfg_ready,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic                 out_last,
    output logic                 flush_sel,
    output logic                 load_hold,
    output logic [OFF_W-1:0]     shift,
    output logic [WCNT_W-1:0]    dst_idx,
    output logic [OFF_W-1:0]     dst_off,
    output logic [WCNT_W-1:0]    end_pos
);

    aln_state_e          state_q;
    logic [OFF_W-1:0]    sh_q, dst_q;
    logic                carry_q, flush_q;
    logic [WCNT_W-1:0]   src_words_q, dst_words_q, end_q;
    logic [WCNT_W-1:0]   src_idx_q, dst_idx_q;

    logic                prime, src_last, in_fire, out_fire, take;
    logic [WCNT_W-1:0]   s_words, d_words;
    logic                carry_n;

    assign s_words = words_spanned(cfg.src_off, cfg.count);
    assign d_words = words_spanned(cfg.dst_off, cfg.count);
    assign carry_n = cfg.src_off > cfg.dst_off;

    assign cfg_ready = (state_q == ST_IDLE);
    assign take      = start && cfg_ready;
    assign prime     = carry_q && (src_idx_q == '0);
    assign src_last  = (src_idx_q == src_words_q - 1'b1);

    assign in_ready  = (state_q == ST_RUN) && (prime || out_ready);
    assign out_valid = ((state_q == ST_RUN) && in_valid && !prime) ||
                       (state_q == ST_FLUSH);
    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;
    assign out_last  = (dst_idx_q == dst_words_q - 1'b1);

    assign flush_sel = (state_q == ST_FLUSH);
    assign load_hold = in_fire;
    assign shift     = sh_q;
    assign dst_idx   = dst_idx_q;
    assign dst_off   = dst_q;
    assign end_pos   = end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            sh_q        <= '0;
            dst_q       <= '0;
            carry_q     <= 1'b0;
            flush_q     <= 1'b0;
            src_words_q <= '0;
            dst_words_q <= '0;
            end_q       <= '0;
            src_idx_q   <= '0;
            dst_idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        state_q     <= ST_RUN;
                        sh_q        <= cfg.dst_off - cfg.src_off;
                        dst_q       <= cfg.dst_off;
                        carry_q     <= carry_n;
                        src_words_q <= s_words;
                        dst_words_q <= d_words;
                        flush_q     <= ({1'b0, d_words} + (WCNT_W+1)'(carry_n))
                                       > {1'b0, s_words};
                        end_q       <= WCNT_W'(cfg.dst_off) + WCNT_W'(cfg.count);
                        src_idx_q   <= '0;
                        dst_idx_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (in_fire) begin
                        src_idx_q <= src_idx_q + 1'b1;
                        if (src_last) state_q <= flush_q ? ST_FLUSH : ST_IDLE;
                    end
                    if (out_fire) dst_idx_q <= dst_idx_q + 1'b1;
                end
                ST_FLUSH: begin
                    if (out_fire) begin
                        dst_idx_q <= dst_idx_q + 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R7: outside priming, a source word leaves only with an output word
    assert_input_pairs_output_R7: assert property (@(posedge clk) disable iff (rst)
        (in_fire && !prime) |-> out_fire);

    // R8: accepting a start makes the block busy
    assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
        take |=> !cfg_ready);

    // R8: a transfer carries at least one byte
    assert_count_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        take |-> (cfg.count != '0));

    // R5: acceptance of the final word ends the transfer
    assert_last_returns_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (out_fire && out_last) |=> cfg_ready);

endmodule

// File: rtl/aln_merge.sv
module aln_merge
    import aln_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              flush,
    input  logic [OFF_W-1:0]  shift,
    input  logic [DW-1:0]     in_data,
    output logic [DW-1:0]     out_data
);

    logic [DW-1:0] hold_q;
    logic [DW-1:0] cur;

    always_ff @(posedge clk) begin
        if (rst)       hold_q <= '0;
        else if (load) hold_q <= in_data;
    end

    assign cur      = flush ? '0 : in_data;
    assign out_data = lane_merge(cur, hold_q, shift);

endmodule

// File: rtl/aln_enables.sv
module aln_enables
    import aln_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               valid,
    input  logic [WCNT_W-1:0]  dst_idx,
    input  logic [OFF_W-1:0]   dst_off,
    input  logic [WCNT_W-1:0]  end_pos,
    output logic [LANES-1:0]   be
);

    localparam int unsigned POS_W = WCNT_W + OFF_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [POS_W-1:0] pos;
        assign pos   = {dst_idx, OFF_W'(k)};
        assign be[k] = (pos >= POS_W'(dst_off)) && (pos < POS_W'(end_pos));
    end

    // R4: no emitted word is empty
    assert_be_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
        valid |-> (be != '0));

endmodule

// File: rtl/byte_realigner.sv
module byte_realigner
    import aln_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [OFF_W-1:0]     cfg_src_off,
    input  logic [OFF_W-1:0]     cfg_dst_off,
    input  logic [CNT_W-1:0]     cfg_count,
    output logic                 cfg_ready,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [DW-1:0]        in_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [DW-1:0]        out_data,
    output logic [LANES-1:0]     out_be,
    output logic                 out_last
);

    aln_cfg_t            cfg;
    logic                flush_sel, load_hold;
    logic [OFF_W-1:0]    shift, dst_off;
    logic [WCNT_W-1:0]   dst_idx, end_pos;

    assign cfg = '{src_off: cfg_src_off, dst_off: cfg_dst_off, count: cfg_count};

    aln_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg       (cfg),
        .cfg_ready (cfg_ready),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_last  (out_last),
        .flush_sel (flush_sel),
        .load_hold (load_hold),
        .shift     (shift),
        .dst_idx   (dst_idx),
        .dst_off   (dst_off),
        .end_pos   (end_pos)
    );

    aln_merge u_merge (
        .clk      (clk),
        .rst      (rst),
        .load     (load_hold),
        .flush    (flush_sel),
        .shift    (shift),
        .in_data  (in_data),
        .out_data (out_data)
    );

    aln_enables u_enables (
        .clk     (clk),
        .rst     (rst),
        .valid   (out_valid),
        .dst_idx (dst_idx),
        .dst_off (dst_off),
        .end_pos (end_pos),
        .be      (out_be)
    );

endmodule

// File: tb/byte_realigner_bench.sv
`timescale 1ns/1ps
module byte_realigner_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  cfg_src_off = '0;
    logic [1:0]  cfg_dst_off = '0;
    logic [11:0] cfg_count = '0;
    logic        cfg_ready;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic [3:0]  out_be;
    logic        out_last;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    byte_realigner u_byte_realigner (
        .clk(clk), .rst(rst), .start(start),
        .cfg_src_off(cfg_src_off), .cfg_dst_off(cfg_dst_off), .cfg_count(cfg_count),
        .cfg_ready(cfg_ready), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_be(out_be), .out_last(out_last)
    );

    function automatic logic [7:0] pat(input int pos, input int so, input int dof, input int n);
        return 8'((pos * 37 + so * 5 + dof * 3 + n) & 255);
    endfunction

    function automatic logic [31:0] src_word(input int w, input int so, input int dof, input int n);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            int p;
            p = 4 * w + k - so;
            v[8*k +: 8] = (p >= 0 && p < n) ? pat(p, so, dof, n) : 8'(8'hA5 ^ k);
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_case(input int so, input int dof, input int n, input int mode);
        int s_words, d_words, carry, flush, w, j, cyc;
        bit ifire, ofire;
        s_words = (so + n + 3) / 4;
        d_words = (dof + n + 3) / 4;
        carry   = (so > dof) ? 1 : 0;
        flush   = (d_words + carry > s_words) ? 1 : 0;
        w = 0; j = 0; cyc = 0;

        start = 1'b1;
        cfg_src_off = 2'(so); cfg_dst_off = 2'(dof); cfg_count = 12'(n);
        #1;
        check(cfg_ready == 1'b1, "R8 start when ready", 32'(cfg_ready), 32'd1);
        @(negedge clk);
        start = 1'b0;
        #1;
        check(cfg_ready == 1'b0, "R8 busy after start", 32'(cfg_ready), 32'd0);

        while ((w < s_words || j < d_words) && cyc < 200) begin
            in_valid  = (w < s_words);
            in_data   = src_word(w, so, dof, n);
            out_ready = (mode == 0) ? 1'b1 : (((cyc * 7 + so + n) % 3) != 0);
            start     = (cyc == 1);
            cfg_src_off = 2'd3; cfg_dst_off = 2'd0; cfg_count = 12'd5;
            #1;
            ifire = in_valid && in_ready;
            ofire = out_valid && out_ready;
            if (ifire && !out_ready && !(carry == 1 && w == 0))
                check(1'b0, "R7 input taken during stall", 32'(w), 32'(s_words));
            if (w >= s_words)
                check(in_ready == 1'b0, "R9 in_ready after last source word", 32'(in_ready), 32'd0);
            if (ofire) begin
                logic [3:0]  ebe;
                logic [31:0] edata, mask;
                ebe = '0; edata = '0; mask = '0;
                for (int k = 0; k < 4; k++) begin
                    int g;
                    g = 4 * j + k;
                    if (g >= dof && g < dof + n) begin
                        ebe[k] = 1'b1;
                        mask[8*k +: 8] = 8'hFF;
                        edata[8*k +: 8] = pat(g - dof, so, dof, n);
                    end
                end
                check(out_be == ebe, (j == 0) ? "R3 first-word enables" : "R4 word enables",
                      32'(out_be), 32'(ebe));
                check((out_data & mask) == edata, "R2 realigned bytes", out_data & mask, edata);
                check(out_last == (j == d_words - 1), "R5 last flag", 32'(out_last),
                      32'(j == d_words - 1));
                j++;
            end
            if (ifire) w++;
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        in_valid = 1'b0;
        out_ready = 1'b0;
        #1;
        check(j == d_words, "R5 output word count", 32'(j), 32'(d_words));
        check(w == s_words, "R9 source word count", 32'(w), 32'(s_words));
        check(cfg_ready == 1'b1 && out_valid == 1'b0, "R8 idle after last word",
              32'({cfg_ready, out_valid}), 32'b10);
        if (mode == 0)
            check(cyc == s_words + flush, "R6 full-rate cycles", 32'(cyc), 32'(s_words + flush));
        @(negedge clk);
    endtask

    initial begin
        #(5 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(cfg_ready == 1'b1 && out_valid == 1'b0 && in_ready == 1'b0,
              "R1 reset state", 32'({cfg_ready, out_valid, in_ready}), 32'b100);
        @(negedge clk);
        for (int mode = 0; mode < 2; mode++)
            for (int so = 0; so < 4; so++)
                for (int dof = 0; dof < 4; dof++)
                    for (int n = 1; n <= 13; n++)
                        run_case(so, dof, n, mode);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule